// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block takes charge of the row and column strobes of an asynchronous DRAM whenever the memory needs housekeeping. After reset it keeps both strobes high for a power-up pause. It then runs a fixed number of initialisation cycles, each of them a CAS-before-RAS (CBR) refresh, and gives the strobes back to the access controller. In normal operation an interval timer records a refresh obligation once per retention period divided by the row count. The block then requests the strobes, waits for a grant and runs the pending refreshes back to back.

On request the block starts a self-refresh: a CBR start whose strobes are then held low for at least a minimum time, and for as long as the request stays high. On exit both strobes are raised in the same cycle. A burst refresh of every row follows before the strobes are released. Throughout any cycle the sequencer drives, write-enable and output-enable are held high, so the device never enters its test mode and its data pins stay high-impedance. When the sequencer does not own the strobes, the access controller's strobe inputs pass straight through.

States: `S_PWRUP` (power-up pause), `S_INIT` (initialisation refreshes), `S_IDLE` (strobes released), `S_WAIT` (request raised, no grant yet), `S_REFRESH` (granted normal refresh), `S_SELF` (self-refresh), `S_BURST` (post-exit burst). Transitions:
- PWRUP→INIT when the pause has elapsed.
- INIT→IDLE after the last initialisation cycle.
- IDLE→WAIT when debt is pending or self-refresh is requested.
- WAIT→SELF, WAIT→REFRESH or WAIT→IDLE on grant, in that priority.
- WAIT→IDLE when the need disappears before a grant.
- REFRESH→IDLE when no further debt remains or the grant has dropped.
- SELF→BURST at exit.
- BURST→IDLE after the last row.

Top module: `rfs_sequencer`

## Requirements
- R1: While reset is asserted the block owns the strobes (`own_o`=1), drives RAS and CAS high, keeps `req_o` and `done_o` low and reports status 1.
- R2: After reset release, RAS and CAS both stay high for PWRUP_CYC cycles (give or take two) before the first CAS fall.
- R3: Exactly INIT_CYC CBR cycles follow the pause without any grant. The block then releases the strobes (`own_o`=0) and reports status 0.
- R4: In every refresh the sequencer drives, CAS is low for more than CAS_LEAD_CYC samples when RAS falls, and CAS stays low for the whole time RAS is low.
- R5: While the block owns the strobes and CAS is low, `we_n_o` and `oe_n_o` are high, even if the controller drives its own write-enable and output-enable low.
- R6: With the grant held high, one refresh completes per INTERVAL_CYC cycles, so a window of 2100 cycles at INTERVAL_CYC=200 holds exactly 10.
- R7: Refresh debt grows by one per interval up to DEBT_MAX and no further. After a grant, all pending refreshes are served back to back.
- R8: Outside initialisation the block takes the strobes only after `grant_i` is seen high. When not owning, `ras_n_o`, `cas_n_o`, `we_n_o` and `oe_n_o` equal the corresponding controller inputs.
- R9: `done_o` is a one-cycle pulse for each normal refresh that completes.
- R10: A self-refresh begins with CAS low before RAS falls. RAS stays low for at least SELF_MIN_CYC cycles, and for as long as `self_req_i` stays high.
- R11: At self-refresh exit, RAS and CAS rise in the same cycle. A burst of exactly ROWS refreshes then follows with CAS held low between them, so CAS rises once during the burst. Afterwards the status returns to 0.
- R12: `status_o` encodes 0 idle, 1 power-up/init, 2 waiting for grant or refreshing, 3 self-refresh, 4 burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| self_req_i | input | 1 | Level request to enter and stay in self-refresh |
| grant_i | input | 1 | Access controller has released the strobes |
| acc_ras_n_i | input | 1 | Controller RAS, passed through when not owned |
| acc_cas_n_i | input | 1 | Controller CAS, passed through when not owned |
| acc_we_n_i | input | 1 | Controller write-enable, passed through when not owned |
| acc_oe_n_i | input | 1 | Controller output-enable, passed through when not owned |
| req_o | output | 1 | Sequencer wants or holds the strobes |
| done_o | output | 1 | One-cycle pulse per completed normal refresh |
| own_o | output | 1 | Sequencer is driving the strobes |
| status_o | output | 3 | Phase code per R12 |
| ras_n_o | output | 1 | RAS to the DRAM |
| cas_n_o | output | 1 | CAS to the DRAM |
| we_n_o | output | 1 | Write-enable to the DRAM |
| oe_n_o | output | 1 | Output-enable to the DRAM |

## Verification
The bench withholds the grant over one, two, three, five and six intervals. A debt counter that fails to saturate would serve five or six refreshes where four are expected, and one that drops ticks would serve fewer. It drives the controller's write-enable and output-enable low throughout, so a mux that leaked them during a CBR cycle would show a low write-enable while CAS is low: on a real part that is a test-mode entry. Self-refresh is left both at once and after a long hold. A design that ignored the minimum low time, released early, raised CAS apart from RAS, or skipped or shortened the burst would show the wrong RAS-low length, a lone strobe edge, or a burst count other than the row count.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    typedef enum logic [2:0] {
        S_PWRUP   = 3'd0,
        S_INIT    = 3'd1,
        S_IDLE    = 3'd2,
        S_WAIT    = 3'd3,
        S_REFRESH = 3'd4,
        S_SELF    = 3'd5,
        S_BURST   = 3'd6
    } seq_state_t;

    typedef enum logic [1:0] {
        E_IDLE  = 2'd0,
        E_LEAD  = 2'd1,
        E_RASLO = 2'd2,
        E_PRE   = 2'd3
    } eng_state_t;

    localparam logic [2:0] STAT_IDLE    = 3'd0;
    localparam logic [2:0] STAT_INIT    = 3'd1;
    localparam logic [2:0] STAT_REFRESH = 3'd2;
    localparam logic [2:0] STAT_SELF    = 3'd3;
    localparam logic [2:0] STAT_BURST   = 3'd4;

endpackage

// File: rtl/rfs_interval.sv
module rfs_interval #(
    parameter int unsigned INTERVAL_CYC = 3906,
    parameter int unsigned DEBT_MAX     = 8,
    localparam int unsigned TW = $clog2(INTERVAL_CYC),
    localparam int unsigned DW = $clog2(DEBT_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_i,
    input  logic          clr_i,
    output logic          tick_o,
    output logic [DW-1:0] debt_o
);

    logic [TW-1:0] tmr_q;

    assign tick_o = (tmr_q == TW'(INTERVAL_CYC - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (tick_o) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            debt_o <= '0;
        end else begin
            unique case ({tick_o, dec_i})
                2'b10: if (debt_o < DW'(DEBT_MAX)) debt_o <= debt_o + 1'b1;
                2'b01: if (debt_o != '0) debt_o <= debt_o - 1'b1;
                default: debt_o <= debt_o;
            endcase
        end
    end

endmodule

// File: rtl/rfs_cbr_engine.sv
module rfs_cbr_engine
    import rfs_pkg::*;
#(
    parameter int unsigned LEAD_CYC  = 2,
    parameter int unsigned RASLO_CYC = 15,
    parameter int unsigned PRE_CYC   = 10,
    localparam int unsigned M1 = (LEAD_CYC > RASLO_CYC) ? LEAD_CYC : RASLO_CYC,
    localparam int unsigned MX = (M1 > PRE_CYC) ? M1 : PRE_CYC,
    localparam int unsigned CW = $clog2(MX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic hold_i,
    input  logic keep_cas_i,
    output logic idle_o,
    output logic raslo_o,
    output logic done_o,
    output logic ras_n_o,
    output logic cas_n_o
);

    eng_state_t    st_q;
    logic [CW-1:0] cnt_q;
    logic          park_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= E_IDLE;
            cnt_q  <= '0;
            park_q <= 1'b0;
        end else begin
            unique case (st_q)
                E_IDLE: begin
                    if (start_i) begin
                        st_q  <= E_LEAD;
                        cnt_q <= '0;
                    end else if (!keep_cas_i) begin
                        park_q <= 1'b0;
                    end
                end
                E_LEAD: begin
                    park_q <= 1'b0;
                    if (cnt_q == CW'(LEAD_CYC - 1)) begin
                        st_q  <= E_RASLO;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                E_RASLO: begin
                    if (cnt_q >= CW'(RASLO_CYC - 1)) begin
                        if (!hold_i) begin
                            st_q  <= E_PRE;
                            cnt_q <= '0;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                E_PRE: begin
                    if (cnt_q == CW'(PRE_CYC - 1)) begin
                        st_q   <= E_IDLE;
                        cnt_q  <= '0;
                        park_q <= keep_cas_i;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= E_IDLE;
            endcase
        end
    end

    always_comb begin
        idle_o  = (st_q == E_IDLE);
        raslo_o = (st_q == E_RASLO);
        done_o  = (st_q == E_PRE) && (cnt_q == CW'(PRE_CYC - 1));
        ras_n_o = (st_q != E_RASLO);
        cas_n_o = !((st_q == E_LEAD) || (st_q == E_RASLO) ||
                    ((st_q == E_PRE) && keep_cas_i) ||
                    ((st_q == E_IDLE) && park_q));
    end

endmodule

// File: rtl/rfs_sequencer.sv
module rfs_sequencer
    import rfs_pkg::*;
#(
    parameter int unsigned PWRUP_CYC    = 50000,
    parameter int unsigned INIT_CYC     = 8,
    parameter int unsigned ROWS         = 1024,
    parameter int unsigned INTERVAL_CYC = 3906,
    parameter int unsigned DEBT_MAX     = 8,
    parameter int unsigned CAS_LEAD_CYC = 2,
    parameter int unsigned RAS_LOW_CYC  = 15,
    parameter int unsigned PRE_CYC      = 10,
    parameter int unsigned SELF_MIN_CYC = 25000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       self_req_i,
    input  logic       grant_i,
    input  logic       acc_ras_n_i,
    input  logic       acc_cas_n_i,
    input  logic       acc_we_n_i,
    input  logic       acc_oe_n_i,
    output logic       req_o,
    output logic       done_o,
    output logic       own_o,
    output logic [2:0] status_o,
    output logic       ras_n_o,
    output logic       cas_n_o,
    output logic       we_n_o,
    output logic       oe_n_o
);

    localparam int unsigned DW  = $clog2(DEBT_MAX + 1);
    localparam int unsigned WW  = $clog2(PWRUP_CYC + 1);
    localparam int unsigned MW  = $clog2(SELF_MIN_CYC + 1);
    localparam int unsigned CMX = (ROWS > INIT_CYC) ? ROWS : INIT_CYC;
    localparam int unsigned CCW = $clog2(CMX + 1);

    seq_state_t     state_q, state_d;
    logic [WW-1:0]  wait_cnt;
    logic [MW-1:0]  min_cnt;
    logic [CCW-1:0] cyc_cnt;
    logic           sr_launched;

    logic          tick, debt_clr;
    logic [DW-1:0] debt;
    logic          eng_start, eng_hold, eng_keep;
    logic          eng_idle, eng_raslo, eng_done, eng_ras_n, eng_cas_n;
    logic          more, last_init, last_row, pwr_done;

    assign more      = ((debt > DW'(1)) || tick) && grant_i;
    assign last_init = (cyc_cnt == CCW'(INIT_CYC - 1));
    assign last_row  = (cyc_cnt == CCW'(ROWS - 1));
    assign pwr_done  = (wait_cnt == WW'(PWRUP_CYC - 1));
    assign debt_clr  = ((state_q == S_INIT) || (state_q == S_BURST)) && (state_d == S_IDLE);

    rfs_interval #(
        .INTERVAL_CYC (INTERVAL_CYC),
        .DEBT_MAX     (DEBT_MAX)
    ) intv_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .dec_i  (done_o),
        .clr_i  (debt_clr),
        .tick_o (tick),
        .debt_o (debt)
    );

    rfs_cbr_engine #(
        .LEAD_CYC  (CAS_LEAD_CYC),
        .RASLO_CYC (RAS_LOW_CYC),
        .PRE_CYC   (PRE_CYC)
    ) eng_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (eng_start),
        .hold_i     (eng_hold),
        .keep_cas_i (eng_keep),
        .idle_o     (eng_idle),
        .raslo_o    (eng_raslo),
        .done_o     (eng_done),
        .ras_n_o    (eng_ras_n),
        .cas_n_o    (eng_cas_n)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_PWRUP:   if (pwr_done) state_d = S_INIT;
            S_INIT:    if (eng_done && last_init) state_d = S_IDLE;
            S_IDLE:    if (self_req_i || (debt != '0)) state_d = S_WAIT;
            S_WAIT: begin
                if (grant_i) begin
                    if (self_req_i)          state_d = S_SELF;
                    else if (debt != '0)     state_d = S_REFRESH;
                    else                     state_d = S_IDLE;
                end else if (!self_req_i && (debt == '0)) begin
                    state_d = S_IDLE;
                end
            end
            S_REFRESH: if (eng_done && !more) state_d = S_IDLE;
            S_SELF:    if (eng_done) state_d = S_BURST;
            S_BURST:   if (eng_done && last_row) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register and phase counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_PWRUP;
            wait_cnt    <= '0;
            min_cnt     <= '0;
            cyc_cnt     <= '0;
            sr_launched <= 1'b0;
        end else begin
            state_q <= state_d;
            if ((state_q == S_PWRUP) && !pwr_done) wait_cnt <= wait_cnt + 1'b1;
            if (state_q != state_d) begin
                cyc_cnt <= '0;
            end else if (eng_done && ((state_q == S_INIT) || (state_q == S_BURST))) begin
                cyc_cnt <= cyc_cnt + 1'b1;
            end
            if (state_q != S_SELF) begin
                min_cnt     <= '0;
                sr_launched <= 1'b0;
            end else begin
                if (eng_start) sr_launched <= 1'b1;
                if (eng_raslo && (min_cnt < MW'(SELF_MIN_CYC))) min_cnt <= min_cnt + 1'b1;
            end
        end
    end

    // outputs and engine control
    always_comb begin
        eng_start = 1'b0;
        eng_keep  = 1'b0;
        eng_hold  = 1'b0;
        own_o     = 1'b1;
        req_o     = 1'b0;
        status_o  = STAT_IDLE;
        unique case (state_q)
            S_PWRUP: begin
                status_o = STAT_INIT;
            end
            S_INIT: begin
                status_o  = STAT_INIT;
                eng_start = eng_idle;
                eng_keep  = !last_init;
            end
            S_IDLE: begin
                own_o = 1'b0;
            end
            S_WAIT: begin
                own_o    = 1'b0;
                req_o    = 1'b1;
                status_o = STAT_REFRESH;
            end
            S_REFRESH: begin
                req_o     = 1'b1;
                status_o  = STAT_REFRESH;
                eng_start = eng_idle;
                eng_keep  = more;
            end
            S_SELF: begin
                req_o     = 1'b1;
                status_o  = STAT_SELF;
                eng_start = eng_idle && !sr_launched;
                eng_hold  = (min_cnt < MW'(SELF_MIN_CYC)) || self_req_i;
            end
            S_BURST: begin
                req_o     = 1'b1;
                status_o  = STAT_BURST;
                eng_start = eng_idle;
                eng_keep  = !last_row;
            end
            default: begin
                own_o = 1'b0;
            end
        endcase
        done_o  = eng_done && (state_q == S_REFRESH);
        ras_n_o = own_o ? eng_ras_n : acc_ras_n_i;
        cas_n_o = own_o ? eng_cas_n : acc_cas_n_i;
        we_n_o  = own_o ? 1'b1      : acc_we_n_i;
        oe_n_o  = own_o ? 1'b1      : acc_oe_n_i;
    end

endmodule

// File: rtl/rfs_sequencer_chk.sv
module rfs_sequencer_chk #(
    parameter int unsigned DEBT_MAX     = 8,
    parameter int unsigned SELF_MIN_CYC = 25000,
    localparam int unsigned DW = $clog2(DEBT_MAX + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          grant_i,
    input logic          own_o,
    input logic          done_o,
    input logic [2:0]    status_o,
    input logic          ras_n_o,
    input logic          cas_n_o,
    input logic          we_n_o,
    input logic          oe_n_o,
    input logic [DW-1:0] debt
);

    logic [31:0] lo_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt <= '0;
        end else if ((status_o == 3'd3) && !ras_n_o) begin
            if (lo_cnt != 32'hFFFF_FFFF) lo_cnt <= lo_cnt + 1'b1;
        end else begin
            lo_cnt <= '0;
        end
    end

    p_cbr_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (own_o && $past(own_o) && $fell(ras_n_o)) |-> (!cas_n_o && !$past(cas_n_o)));

    p_cas_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (own_o && !ras_n_o) |-> !cas_n_o);

    p_no_testmode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (own_o && !cas_n_o) |-> (we_n_o && oe_n_o));

    p_debt_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        debt <= DW'(DEBT_MAX));

    p_grant_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own_o) |-> $past(grant_i));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_self_min_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o == 3'd3) && $rose(ras_n_o)) |-> (lo_cnt >= 32'(SELF_MIN_CYC)));

    p_self_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o == 3'd3) && $rose(ras_n_o)) |-> cas_n_o);

endmodule

bind rfs_sequencer rfs_sequencer_chk #(
    .DEBT_MAX     (DEBT_MAX),
    .SELF_MIN_CYC (SELF_MIN_CYC)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant_i  (grant_i),
    .own_o    (own_o),
    .done_o   (done_o),
    .status_o (status_o),
    .ras_n_o  (ras_n_o),
    .cas_n_o  (cas_n_o),
    .we_n_o   (we_n_o),
    .oe_n_o   (oe_n_o),
    .debt     (debt)
);

// File: tb/rfs_sequencer_tb_top.sv
`timescale 1ns/1ps
module rfs_sequencer_tb_top;

    localparam int PWRUP    = 100;
    localparam int INITC    = 8;
    localparam int ROWS     = 16;
    localparam int INTERVAL = 200;
    localparam int DMAX     = 4;
    localparam int LEAD     = 2;
    localparam int RASLO    = 4;
    localparam int PRE      = 3;
    localparam int SMIN     = 50;

    // stall intervals withheld before grant, and refreshes then expected
    localparam int STALL_TBL [5] = '{1, 2, 3, 5, 6};
    localparam int EXP_TBL   [5] = '{1, 2, 3, 4, 4};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic self_req = 1'b0, grant = 1'b0;
    logic acc_ras_n = 1'b1, acc_cas_n = 1'b1, acc_we_n = 1'b0, acc_oe_n = 1'b0;
    logic req_o, done_o, own_o, ras_n_o, cas_n_o, we_n_o, oe_n_o;
    logic [2:0] status_o;

    int checks = 0, fails = 0;
    int done_cnt = 0, cbr_bad = 0, we_bad = 0, done_wide = 0, cas_run = 0;
    logic prev_ras = 1'b1, prev_done = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rfs_sequencer #(
        .PWRUP_CYC(PWRUP), .INIT_CYC(INITC), .ROWS(ROWS), .INTERVAL_CYC(INTERVAL),
        .DEBT_MAX(DMAX), .CAS_LEAD_CYC(LEAD), .RAS_LOW_CYC(RASLO), .PRE_CYC(PRE),
        .SELF_MIN_CYC(SMIN)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .self_req_i(self_req), .grant_i(grant),
        .acc_ras_n_i(acc_ras_n), .acc_cas_n_i(acc_cas_n), .acc_we_n_i(acc_we_n),
        .acc_oe_n_i(acc_oe_n), .req_o(req_o), .done_o(done_o), .own_o(own_o),
        .status_o(status_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
        .we_n_o(we_n_o), .oe_n_o(oe_n_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // protocol monitor (R4, R5, R9)
    always @(negedge clk) begin
        if (rst_n) begin
            int run_now;
            run_now = cas_n_o ? 0 : cas_run + 1;
            if (own_o && prev_ras && !ras_n_o && (run_now <= LEAD)) cbr_bad++;
            if (own_o && !ras_n_o && cas_n_o) cbr_bad++;
            if (own_o && !cas_n_o && (!we_n_o || !oe_n_o)) we_bad++;
            if (done_o && prev_done) done_wide++;
            if (done_o) done_cnt++;
            cas_run   = run_now;
            prev_ras  = ras_n_o;
            prev_done = done_o;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog all-requirements act=%0d exp=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic self_run(input int drop_at, input int lo_min, input int lo_max);
        int n;
        int falls;
        int rises;
        logic pr;
        logic pc;
        self_req = 1'b1;
        while (status_o != 3'd3) @(negedge clk);
        chk(status_o == 3'd3, "R12 self status", status_o, 3);
        while (ras_n_o) @(negedge clk);
        chk(!cas_n_o, "R10 CAS low at self entry", cas_n_o, 0);
        n = 1;
        forever begin
            if (n == drop_at) self_req = 1'b0;
            @(negedge clk);
            if (ras_n_o) break;
            n++;
        end
        chk((n >= lo_min) && (n <= lo_max), "R10 self RAS-low length", n, lo_min);
        chk(cas_n_o == 1'b1, "R11 CAS rises with RAS at exit", cas_n_o, 1);
        falls = 0; rises = 0; pr = ras_n_o; pc = cas_n_o;
        while (status_o != 3'd0) begin
            @(negedge clk);
            if (status_o == 3'd4) begin
                if (pr && !ras_n_o) falls++;
                if (!pc && cas_n_o) rises++;
            end
            pr = ras_n_o; pc = cas_n_o;
        end
        chk(falls == ROWS, "R11 burst refresh count", falls, ROWS);
        chk(rises == 1, "R11 CAS parked low during burst", rises, 1);
    endtask

    initial begin
        int n;
        int falls;
        int d0;
        logic pr;

        // R1: reset state
        repeat (4) @(negedge clk);
        chk(own_o == 1'b1, "R1 own in reset", own_o, 1);
        chk(ras_n_o && cas_n_o, "R1 strobes high in reset", {ras_n_o, cas_n_o}, 3);
        chk(status_o == 3'd1, "R1 status in reset", status_o, 1);
        chk(!req_o && !done_o, "R1 req/done low", {req_o, done_o}, 0);
        rst_n = 1'b1;

        // R2: power-up pause
        n = 0;
        forever begin
            @(negedge clk);
            if (!cas_n_o || !ras_n_o) break;
            n++;
        end
        chk((n >= PWRUP) && (n <= PWRUP + 2), "R2 power-up pause", n, PWRUP);

        // R3: initialisation cycles, no grant given
        falls = 0; pr = ras_n_o;
        while (status_o != 3'd0) begin
            @(negedge clk);
            if (pr && !ras_n_o) falls++;
            pr = ras_n_o;
        end
        chk(falls == INITC, "R3 init CBR count", falls, INITC);
        chk(own_o == 1'b0, "R3 strobes released", own_o, 0);

        // R8: pass-through while not owned
        acc_ras_n = 1'b0; acc_cas_n = 1'b0; acc_we_n = 1'b1; acc_oe_n = 1'b1;
        @(negedge clk);
        chk(!ras_n_o && !cas_n_o && we_n_o && oe_n_o, "R8 pass-through low strobes",
            {ras_n_o, cas_n_o, we_n_o, oe_n_o}, 3);
        acc_ras_n = 1'b1; acc_cas_n = 1'b1; acc_we_n = 1'b0; acc_oe_n = 1'b0;
        @(negedge clk);
        chk(ras_n_o && cas_n_o && !we_n_o && !oe_n_o, "R8 pass-through high strobes",
            {ras_n_o, cas_n_o, we_n_o, oe_n_o}, 12);

        // R7/R8/R9/R12: debt accumulation and back-to-back service
        for (int i = 0; i < 5; i++) begin
            while (!req_o) @(negedge clk);
            repeat ((STALL_TBL[i] - 1) * INTERVAL + INTERVAL / 2) @(negedge clk);
            chk(!own_o && req_o && ras_n_o, "R8 no takeover without grant",
                {own_o, req_o, ras_n_o}, 3);
            chk(status_o == 3'd2, "R12 waiting status", status_o, 2);
            grant = 1'b1;
            d0 = done_cnt;
            repeat (80) @(negedge clk);
            chk(done_cnt - d0 == EXP_TBL[i], "R7 debt served after stall", done_cnt - d0, EXP_TBL[i]);
            grant = 1'b0;
        end

        // R6: refresh rate with grant always available
        grant = 1'b1;
        d0 = done_cnt;
        while (done_cnt == d0) @(negedge clk);
        d0 = done_cnt;
        repeat (2100) @(negedge clk);
        chk(done_cnt - d0 == 10, "R6 refreshes per 2100 cycles", done_cnt - d0, 10);

        // R10/R11: self-refresh, long hold then immediate release
        self_run(120, 120, 123);
        self_run(1, SMIN, SMIN + 3);

        // protocol monitors
        chk(cbr_bad == 0, "R4 CBR ordering violations", cbr_bad, 0);
        chk(we_bad == 0, "R5 write/output enable low while owned", we_bad, 0);
        chk(done_wide == 0, "R9 done wider than one cycle", done_wide, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule